// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block finds branches during instruction fetch, before the instruction has been decoded, and supplies where they go. It is a direct-mapped table of 64 entries indexed by fetch PC bits [7:2]. Each entry holds a valid bit, a 30-bit tag equal to PC[31:2] and a 30-bit word-aligned target. Entries carry no direction state. A tag match marks the fetched instruction as a branch, and it gates a taken/not-taken bit from an external direction predictor. The next fetch PC is the stored target only when both agree. In every other case it is the sequential PC plus 4. A branch that decode finds but that missed in the table is treated as not taken.

When a branch resolves, the execute stage presents it on the resolution port. That includes whether fetch saw a hit and which next PC fetch chose. The block writes the entry at that index with the branch's tag and target. It also classifies any recovery. A taken branch that fetch did not recognise is a misfetch. A recognised branch whose chosen next PC was wrong, in direction or in target, is a mispredict. On the cycle after resolution, the block raises the matching event flag together with a redirect valid and the correct PC.

Top module: `btb_fetch`

## Requirements
- R1: After reset every entry is invalid. No lookup hits until the first resolution is written, and the misfetch, mispredict and redirect outputs are 0.
- R2: A lookup hits only if the entry at index PC[7:2] is valid and its tag equals all of PC[31:2]. A PC that shares the index but differs in any upper bit misses. PC[1:0] is ignored.
- R3: On a hit with the direction input at 1 (taken), next_pc_o is the stored target with bits [1:0] at 0.
- R4: On a miss, whatever the direction input, and on a hit with the direction input at 0, next_pc_o is fetch_pc_i + 4.
- R5: Every resolution writes its index with valid set, tag = res_pc_i[31:2] and target = res_target_i[31:2], replacing any earlier entry there. A lookup made after the write sees it.
- R6: A lookup in the same cycle as a resolution that writes the same index sees the contents from before the write.
- R7: A resolution with res_taken_i=1 and res_pred_hit_i=0 makes misfetch_o=1 in the next cycle, with redirect_valid_o=1 and redirect_pc_o=res_target_i.
- R8: A resolution with res_pred_hit_i=1 whose res_pred_next_i differs from the correct next PC makes mispredict_o=1 in the next cycle, with redirect_valid_o=1 and redirect_pc_o set to that correct PC. The correct next PC is res_target_i if the branch was taken and res_pc_i + 4 if it was not.
- R9: No event and no redirect follows a cycle without a resolution. None follows a not-taken branch that missed, or a hit whose chosen next PC was correct. Each event lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | PC being fetched |
| dir_taken_i | input | 1 | External direction prediction for fetch_pc_i (1 = taken) |
| hit_o | output | 1 | fetch_pc_i is a known branch |
| next_pc_o | output | 32 | Predicted next fetch PC |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | 32 | PC of the resolving branch |
| res_taken_i | input | 1 | Actual direction |
| res_target_i | input | 32 | Actual taken target |
| res_pred_hit_i | input | 1 | Fetch saw a hit for this branch |
| res_pred_next_i | input | 32 | Next PC fetch chose after this branch |
| misfetch_o | output | 1 | Taken branch was not recognised at fetch |
| mispredict_o | output | 1 | Recognised branch went to the wrong PC |
| redirect_valid_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | 32 | Correct fetch PC after recovery |

## Verification
Corrupt table state shows up on the lookup path in the same cycle. A lost valid bit or a truncated tag appears as a wrong hit_o, and a bad target appears in next_pc_o, as soon as that PC is fetched again. The bench therefore reuses a few PCs that share each index, so that aliasing and overwriting are hit within a handful of cycles. A classification fault appears one cycle after the resolution as a wrong event flag or redirect PC. Both paths are compared against the reference model on every clock, so a fault is reported no later than the first cycle it becomes visible at the ports.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    EV_NONE       = 2'd0,
    EV_MISFETCH   = 2'd1,
    EV_MISPREDICT = 2'd2
  } btb_event_e;
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] rd_pc_i,
  output logic            rd_hit_o,
  output logic [PC_W-1:0] rd_tgt_o,
  input  logic            wr_en_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic [PC_W-1:0] wr_tgt_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - 2;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TAG_W-1:0]   tgt_q [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  assign rd_idx = rd_pc_i[IDX_W+1:2];
  assign wr_idx = wr_pc_i[IDX_W+1:2];

  // read old contents; writes land at the edge
  assign rd_hit_o = vld_q[rd_idx] && (tag_q[rd_idx] == rd_pc_i[PC_W-1:2]);
  assign rd_tgt_o = {tgt_q[rd_idx], 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx] <= wr_pc_i[PC_W-1:2];
      tgt_q[wr_idx] <= wr_tgt_i[PC_W-1:2];
    end
  end

  // R5
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_pred_hit_i,
  input  logic [PC_W-1:0] res_pred_next_i,
  output logic            misfetch_o,
  output logic            mispredict_o,
  output logic            redirect_valid_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  btb_event_e      ev_d, ev_q;
  logic [PC_W-1:0] correct_pc, pc_q;

  assign correct_pc = res_taken_i ? res_target_i : res_pc_i + PC_W'(4);

  always_comb begin
    ev_d = EV_NONE;
    if (res_valid_i) begin
      if (!res_pred_hit_i) begin
        if (res_taken_i) ev_d = EV_MISFETCH;
      end else if (res_pred_next_i != correct_pc) begin
        ev_d = EV_MISPREDICT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= EV_NONE;
      pc_q <= '0;
    end else begin
      ev_q <= ev_d;
      if (ev_d != EV_NONE) pc_q <= correct_pc;
    end
  end

  assign misfetch_o       = (ev_q == EV_MISFETCH);
  assign mispredict_o     = (ev_q == EV_MISPREDICT);
  assign redirect_valid_o = (ev_q != EV_NONE);
  assign redirect_pc_o    = pc_q;

  // R9
  redirect_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> $past(res_valid_i));

  // R7
  misfetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_taken_i && !res_pred_hit_i
      |=> misfetch_o && redirect_pc_o == $past(res_target_i));

  // R8
  bad_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_pred_hit_i && res_taken_i && res_pred_next_i != res_target_i
      |=> mispredict_o);
endmodule

// File: rtl/btb_fetch.sv
module btb_fetch #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            dir_taken_i,
  output logic            hit_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_pred_hit_i,
  input  logic [PC_W-1:0] res_pred_next_i,
  output logic            misfetch_o,
  output logic            mispredict_o,
  output logic            redirect_valid_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  logic [PC_W-1:0] stored_tgt;

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_pc_i  (fetch_pc_i),
    .rd_hit_o (hit_o),
    .rd_tgt_o (stored_tgt),
    .wr_en_i  (res_valid_i),
    .wr_pc_i  (res_pc_i),
    .wr_tgt_i (res_target_i)
  );

  // direction only from external predictor, and only on a hit
  assign next_pc_o = (hit_o && dir_taken_i) ? stored_tgt : fetch_pc_i + PC_W'(4);

  btb_resolve #(.PC_W(PC_W)) u_resolve (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .res_valid_i      (res_valid_i),
    .res_pc_i         (res_pc_i),
    .res_taken_i      (res_taken_i),
    .res_target_i     (res_target_i),
    .res_pred_hit_i   (res_pred_hit_i),
    .res_pred_next_i  (res_pred_next_i),
    .misfetch_o       (misfetch_o),
    .mispredict_o     (mispredict_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o)
  );

  // R4
  seq_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> next_pc_o == fetch_pc_i + PC_W'(4));
endmodule

// File: tb/btb_fetch_bench.sv
module btb_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fpc = 32'h0;
  logic        dir = 1'b0;
  logic        rv = 1'b0, rt = 1'b0, ph = 1'b0;
  logic [31:0] rpc = 32'h0, rtgt = 32'h0, pn = 32'h0;
  logic        hit, mf, mp, rdv;
  logic [31:0] npc, rdpc;

  always #2 clk = ~clk;

  btb_fetch u_btb_fetch (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fpc), .dir_taken_i(dir),
    .hit_o(hit), .next_pc_o(npc), .res_valid_i(rv), .res_pc_i(rpc),
    .res_taken_i(rt), .res_target_i(rtgt), .res_pred_hit_i(ph),
    .res_pred_next_i(pn), .misfetch_o(mf), .mispredict_o(mp),
    .redirect_valid_o(rdv), .redirect_pc_o(rdpc)
  );

  int checks = 0, errors = 0, cycles = 0, writes = 0;

  // reference model
  bit          m_vld [64];
  logic [29:0] m_tag [64];
  logic [29:0] m_tgt [64];
  bit          exp_mf = 0, exp_mp = 0;
  logic [31:0] exp_rpc = 0;
  int          idx;
  bit          exp_hit;
  logic [31:0] exp_next, good;
  string       lbl;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog", "timeout", 32'(cycles), 32'd150000);
        finish_run();
      end
      idx = int'(fpc[7:2]);
      exp_hit = m_vld[idx] && (m_tag[idx] == fpc[31:2]);
      exp_next = (exp_hit && dir) ? {m_tgt[idx], 2'b00} : fpc + 32'd4;
      if (writes == 0)                      lbl = "R1";
      else if (rv && int'(rpc[7:2]) == idx) lbl = "R6";
      else if (exp_hit)                     lbl = "R5";
      else                                  lbl = "R2";
      chk(hit == exp_hit, lbl, "hit", {31'd0, hit}, {31'd0, exp_hit});
      chk(npc == exp_next, (exp_hit && dir) ? "R3" : "R4", "next_pc", npc, exp_next);
      chk(mf == exp_mf, "R7", "misfetch", {31'd0, mf}, {31'd0, exp_mf});
      chk(mp == exp_mp, "R8", "mispredict", {31'd0, mp}, {31'd0, exp_mp});
      chk(rdv == (exp_mf || exp_mp), "R9", "redirect_valid", {31'd0, rdv},
          {31'd0, exp_mf || exp_mp});
      if (exp_mf || exp_mp)
        chk(rdpc == exp_rpc, exp_mf ? "R7" : "R8", "redirect_pc", rdpc, exp_rpc);
      // events for next cycle, then table write at the coming edge
      good = rt ? rtgt : rpc + 32'd4;
      exp_mf = rv && !ph && rt;
      exp_mp = rv && ph && (pn != good);
      if (exp_mf || exp_mp) exp_rpc = good;
      if (rv) begin
        m_vld[int'(rpc[7:2])] = 1'b1;
        m_tag[int'(rpc[7:2])] = rpc[31:2];
        m_tgt[int'(rpc[7:2])] = rtgt[31:2];
        writes++;
      end
    end
  end

  task automatic cyc(input logic [31:0] a_pc, input logic a_dir, input logic a_rv,
                     input logic [31:0] a_rpc, input logic a_rt, input logic [31:0] a_tgt,
                     input logic a_ph, input logic [31:0] a_pn);
    @(posedge clk);
    #1;
    fpc = a_pc; dir = a_dir; rv = a_rv; rpc = a_rpc;
    rt = a_rt; rtgt = a_tgt; ph = a_ph; pn = a_pn;
  endtask

  function automatic logic [31:0] pick_pc();
    return 32'h0001_0000 + (32'($urandom_range(0, 3)) << 8)
                         + (32'($urandom_range(0, 7)) << 2);
  endfunction

  localparam logic [31:0] PA = 32'h0000_1000;
  localparam logic [31:0] PB = 32'h0000_1100; // same index as PA, other tag
  localparam logic [31:0] PC = 32'h0000_1044;

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet while in reset
    chk(!mf && !mp && !rdv, "R1", "events in reset", {29'd0, mf, mp, rdv}, 32'd0);
    rst_n = 1'b1;
    // R1/R4: empty table
    cyc(PA, 1, 0, 0, 0, 0, 0, 0);
    cyc(PC, 0, 0, 0, 0, 0, 0, 0);
    // R7 + R6: misfetch on PA, same-cycle lookup still misses
    cyc(PA, 1, 1, PA, 1, 32'h0000_2000, 0, PA + 4);
    // R5 + R3: now hits and redirects
    cyc(PA, 1, 0, 0, 0, 0, 0, 0);
    cyc(PA, 0, 0, 0, 0, 0, 0, 0);
    // R2: alias misses
    cyc(PB, 1, 0, 0, 0, 0, 0, 0);
    // R8: wrong target on hit, overwrites index with PB
    cyc(PB, 1, 1, PB, 1, 32'h0000_3000, 1, 32'h0000_2000);
    cyc(PA, 1, 0, 0, 0, 0, 0, 0);
    cyc(PB, 1, 0, 0, 0, 0, 0, 0);
    // R9: correct hit, and not-taken miss
    cyc(PB, 1, 1, PB, 1, 32'h0000_3000, 1, 32'h0000_3000);
    cyc(PC, 1, 1, PC, 0, 32'h0000_4000, 0, PC + 4);
    // R8: predicted taken, actually not taken
    cyc(PB, 1, 1, PB, 0, 32'h0000_3000, 1, 32'h0000_3000);
    cyc(PC, 1, 0, 0, 0, 0, 0, 0);
    // random traffic over aliased PCs
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r_pc, r_tgt, r_pn;
      logic        r_t, r_h;
      r_pc  = pick_pc();
      r_t   = 1'($urandom_range(0, 1));
      r_h   = 1'($urandom_range(0, 1));
      r_tgt = {30'($urandom_range(0, 15)), 2'b00} + 32'h0002_0000;
      r_pn  = ($urandom_range(0, 2) != 0) ? (r_t ? r_tgt : r_pc + 4)
                                          : {30'($urandom_range(0, 15)), 2'b00} + 32'h0002_0000;
      cyc(pick_pc(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
          r_pc, r_t, r_tgt, r_h, r_pn);
    end
    cyc(PC, 0, 0, 0, 0, 0, 0, 0);
    cyc(PC, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule